// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the bookkeeping core of a single-channel receive engine. The host prepares receive buffers in a circular ring of descriptors and tells the engine how far it has got by writing a host index. The engine takes frame beats from an abstract stream and counts their bytes into the buffer it is filling. A buffer closes when it is full, or when the stream has been quiet for the programmed timeout while the buffer holds some data. Each close emits a completion event that carries the ring index, advances and publishes the fill index, and can raise a host interrupt.

The block moves no data. Descriptor fetch, memory writes and alignment checks belong to other blocks. Configuration, the host index, status and an overflow byte count sit behind a four-word register port:

| Address | Register |
|---|---|
| 0 | configuration |
| 1 | host index |
| 2 | status |
| 3 | overflow byte count |

Every stream beat carries `BEAT_BYTES` bytes. The stream marks frame boundaries with start and end flags. A microsecond tick input drives the timeout.

Top module: `rx_ring_dma`

## Requirements
- R1: The ring holds 2^L descriptors, where L is config bits 23:20 clamped to the range 5..12. The host index and the fill index are masked to the ring size and wrap to zero after the last entry.
- R2: Config bits 17:16 (value s) set the buffer size to (s+1)·`BUF_UNIT` bytes, which is (s+1)·`BUF_UNIT`/`BEAT_BYTES` beats. The beat that fills a buffer closes it.
- R3: Config bits 31:30 select the channel mode:
  - 10: beats are accepted (`st_ready_o`=1).
  - 00 or 11: no beat is accepted.
  - 01: beats are accepted only until the frame in progress ends with an end-marked beat. After that, offered beats are refused.
- R4: A write to address 1 takes effect only when the masked new value has the same low three bits as the current host index, that is, when the index advances by a multiple of eight. Any other write leaves the index unchanged. Address 1 reads back the masked host index.
- R5: When the fill index equals the host index, no descriptor is free. An accepted beat is then dropped, and the overflow count at address 3 grows by `BEAT_BYTES`, saturating at its maximum. The ring therefore never holds more than size−1 filled buffers.
- R6: Each buffer close produces a one-cycle `done_valid_o` in the cycle after the closing edge. `done_idx_o` carries the closed index, and the fill index (`fill_idx_o`, and status bits 11:0) advances by one modulo the ring size. The fill index changes at no other time.
- R7: Config bits 11:4 (T, non-zero) set the timeout. When a buffer holds data and no beat is stored for 32·T microsecond ticks, the buffer closes. T=0 disables the timeout.
- R8: Config bits 13:12 select the interrupt target. With 01, `irq_o` pulses together with every `done_valid_o`. Any other value keeps `irq_o` low.
- R9: Status bit 24 reads 1 exactly when the channel accepts no beats. This holds after reset, in stop mode, and once a pause has reached the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | 2 | register address (0 config, 1 host index, 2 status, 3 overflow) |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data for `reg_addr_i`, combinational |
| us_tick_i | input | 1 | one-cycle pulse per microsecond |
| st_valid_i | input | 1 | stream beat offered |
| st_sof_i | input | 1 | beat starts a frame |
| st_eof_i | input | 1 | beat ends a frame |
| st_ready_o | output | 1 | beat is taken in this cycle |
| done_valid_o | output | 1 | buffer closed (one cycle) |
| done_idx_o | output | 12 | ring index of the closed buffer |
| fill_idx_o | output | 12 | published fill index |
| irq_o | output | 1 | host interrupt pulse |

## Verification
The timing of each result is fixed:
- A register write shows on the read port one edge later.
- A closing beat yields `done_valid_o`, the new fill index and the interrupt one edge after the edge that takes it.
- A timeout close lands on the 32·T-th tick edge after the last stored beat.

The bench drives inputs at the falling edge. It records completion events through a monitor that samples just after each rising edge. Every check runs at the falling edge that follows the edge where the result is due. The timeout case first confirms that no completion exists one edge early, and then confirms it on the exact edge.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int IDX_W        = 12;
  localparam int RING_LOG_MIN = 5;
  localparam int RING_LOG_MAX = 12;
  localparam int STEP_LOG     = 3;
  localparam int IDLE_BIT     = 24;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_HOST = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_OVF  = 2'd3;

  typedef enum logic [1:0] {
    CH_STOP      = 2'b00,
    CH_PAUSE_EOF = 2'b01,
    CH_RUN       = 2'b10,
    CH_RSVD      = 2'b11
  } ch_mode_e;

  typedef enum logic [1:0] {
    IRQ_NONE  = 2'b00,
    IRQ_HOST  = 2'b01,
    IRQ_RSVD2 = 2'b10,
    IRQ_RSVD3 = 2'b11
  } irq_dest_e;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      cfg_word_o,
  output ch_mode_e         mode_o,
  output logic [1:0]       buf_sel_o,
  output irq_dest_e        irq_dest_o,
  output logic [7:0]       tmo_o,
  output logic [IDX_W-1:0] ring_mask_o,
  output logic [IDX_W-1:0] host_idx_o
);
  logic [31:0]      cfg_q;
  logic [IDX_W-1:0] host_q;
  logic [IDX_W-1:0] host_new;
  logic [3:0]       ring_log;
  logic [IDX_W:0]   span;
  logic             host_ok;

  always_comb begin
    if (cfg_q[23:20] < 4'(RING_LOG_MIN))      ring_log = 4'(RING_LOG_MIN);
    else if (cfg_q[23:20] > 4'(RING_LOG_MAX)) ring_log = 4'(RING_LOG_MAX);
    else                                      ring_log = cfg_q[23:20];
    span        = (IDX_W+1)'(1) << ring_log;
    ring_mask_o = IDX_W'(span - (IDX_W+1)'(1));
  end

  assign mode_o     = ch_mode_e'(cfg_q[31:30]);
  assign buf_sel_o  = cfg_q[17:16];
  assign irq_dest_o = irq_dest_e'(cfg_q[13:12]);
  assign tmo_o      = cfg_q[11:4];
  assign cfg_word_o = cfg_q;

  assign host_new = wdata_i[IDX_W-1:0] & ring_mask_o;
  // index may only move in whole groups of eight descriptors
  assign host_ok  = host_new[STEP_LOG-1:0] == host_q[STEP_LOG-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      host_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_CFG)             cfg_q  <= wdata_i;
      if (addr_i == ADDR_HOST && host_ok) host_q <= host_new;
    end
  end

  assign host_idx_o = host_q & ring_mask_o;
endmodule

// File: rtl/rx_ring_tmo.sv
module rx_ring_tmo #(
  parameter int TICKS_PER_UNIT = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] tmo_i,
  input  logic       partial_i,
  input  logic       store_i,
  output logic       expire_o
);
  localparam int TMO_W = $clog2(255 * TICKS_PER_UNIT + 2);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] limit;
  logic [TMO_W-1:0] cnt_inc;

  assign limit   = TMO_W'(tmo_i) * TMO_W'(TICKS_PER_UNIT);
  assign cnt_inc = cnt_q + TMO_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (store_i || !partial_i) cnt_q <= '0;
    else if (tick_i)               cnt_q <= cnt_inc;
  end

  assign expire_o = partial_i && !store_i && (tmo_i != 8'd0) && tick_i && (cnt_inc >= limit);
endmodule

// File: rtl/rx_ring_fill.sv
module rx_ring_fill
  import rx_ring_pkg::*;
#(
  parameter int UNIT_BEATS = 1024,
  parameter int BEAT_BYTES = 4,
  parameter int OVF_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ch_mode_e         mode_i,
  input  logic [1:0]       buf_sel_i,
  input  irq_dest_e        irq_dest_i,
  input  logic [IDX_W-1:0] ring_mask_i,
  input  logic [IDX_W-1:0] host_idx_i,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             expire_i,
  output logic             ready_o,
  output logic             store_o,
  output logic             partial_o,
  output logic [IDX_W-1:0] fill_idx_o,
  output logic             done_o,
  output logic [IDX_W-1:0] done_idx_o,
  output logic             irq_o,
  output logic [OVF_W-1:0] ovf_cnt_o
);
  localparam int BCNT_W = $clog2(4 * UNIT_BEATS + 1);
  localparam logic [OVF_W-1:0] OVF_MAX  = '1;
  localparam logic [OVF_W-1:0] OVF_STEP = OVF_W'(BEAT_BYTES);

  logic [IDX_W-1:0]  fill_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [BCNT_W-1:0] buf_beats;
  logic [OVF_W-1:0]  ovf_q;
  logic              in_frame_q;
  logic              take, free, drop, full_close, close;
  logic              done_q, irq_q;
  logic [IDX_W-1:0]  done_idx_q;

  assign buf_beats = BCNT_W'((32'(buf_sel_i) + 32'd1) * UNIT_BEATS);

  always_comb begin
    unique case (mode_i)
      CH_RUN:       ready_o = 1'b1;
      CH_PAUSE_EOF: ready_o = in_frame_q;
      default:      ready_o = 1'b0;
    endcase
  end

  assign take       = valid_i && ready_o;
  assign free       = (fill_q & ring_mask_i) != host_idx_i;
  assign store_o    = take && free;
  assign drop       = take && !free;
  assign full_close = store_o && ((bcnt_q + BCNT_W'(1)) >= buf_beats);
  assign close      = full_close || expire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q     <= '0;
      bcnt_q     <= '0;
      done_q     <= 1'b0;
      done_idx_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      done_q <= close;
      irq_q  <= close && (irq_dest_i == IRQ_HOST);
      if (close) begin
        done_idx_q <= fill_q & ring_mask_i;
        fill_q     <= (fill_q + IDX_W'(1)) & ring_mask_i;
        bcnt_q     <= '0;
      end else if (store_o) begin
        bcnt_q <= bcnt_q + BCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
    end else if (take) begin
      if (eof_i)      in_frame_q <= 1'b0;
      else if (sof_i) in_frame_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= '0;
    end else if (drop) begin
      ovf_q <= (ovf_q > OVF_MAX - OVF_STEP) ? OVF_MAX : ovf_q + OVF_STEP;
    end
  end

  assign partial_o  = bcnt_q != '0;
  assign fill_idx_o = fill_q & ring_mask_i;
  assign done_o     = done_q;
  assign done_idx_o = done_idx_q;
  assign irq_o      = irq_q;
  assign ovf_cnt_o  = ovf_q;
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int BUF_UNIT       = 4096,
  parameter int BEAT_BYTES     = 4,
  parameter int OVF_W          = 16,
  parameter int TICKS_PER_UNIT = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        us_tick_i,
  input  logic        st_valid_i,
  input  logic        st_sof_i,
  input  logic        st_eof_i,
  output logic        st_ready_o,
  output logic        done_valid_o,
  output logic [11:0] done_idx_o,
  output logic [11:0] fill_idx_o,
  output logic        irq_o
);
  localparam int UNIT_BEATS = BUF_UNIT / BEAT_BYTES;

  logic [31:0]      cfg_word;
  ch_mode_e         mode;
  logic [1:0]       buf_sel;
  irq_dest_e        irq_dest;
  logic [7:0]       tmo;
  logic [IDX_W-1:0] ring_mask;
  logic [IDX_W-1:0] host_idx;
  logic             store, partial, expire;
  logic [OVF_W-1:0] ovf_cnt;

  rx_ring_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cfg_word_o (cfg_word),
    .mode_o     (mode),
    .buf_sel_o  (buf_sel),
    .irq_dest_o (irq_dest),
    .tmo_o      (tmo),
    .ring_mask_o(ring_mask),
    .host_idx_o (host_idx)
  );

  rx_ring_tmo #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) i_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (us_tick_i),
    .tmo_i    (tmo),
    .partial_i(partial),
    .store_i  (store),
    .expire_o (expire)
  );

  rx_ring_fill #(
    .UNIT_BEATS(UNIT_BEATS),
    .BEAT_BYTES(BEAT_BYTES),
    .OVF_W     (OVF_W)
  ) i_fill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .buf_sel_i  (buf_sel),
    .irq_dest_i (irq_dest),
    .ring_mask_i(ring_mask),
    .host_idx_i (host_idx),
    .valid_i    (st_valid_i),
    .sof_i      (st_sof_i),
    .eof_i      (st_eof_i),
    .expire_i   (expire),
    .ready_o    (st_ready_o),
    .store_o    (store),
    .partial_o  (partial),
    .fill_idx_o (fill_idx_o),
    .done_o     (done_valid_o),
    .done_idx_o (done_idx_o),
    .irq_o      (irq_o),
    .ovf_cnt_o  (ovf_cnt)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CFG:  reg_rdata_o = cfg_word;
      ADDR_HOST: reg_rdata_o[IDX_W-1:0] = host_idx;
      ADDR_STAT: begin
        reg_rdata_o[IDX_W-1:0] = fill_idx_o;
        reg_rdata_o[IDLE_BIT]  = !st_ready_o;
      end
      default:   reg_rdata_o = 32'(ovf_cnt);
    endcase
  end
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [1:0]  cfg_mode,
  input logic [11:0] ring_mask,
  input logic [11:0] host_idx,
  input logic [11:0] fill_idx_o,
  input logic [11:0] done_idx_o,
  input logic        done_valid_o,
  input logic        irq_o,
  input logic        st_ready_o
);
  // R6
  done_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && $stable(ring_mask)) |-> fill_idx_o == ((done_idx_o + 12'd1) & ring_mask));

  // R6
  fill_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(ring_mask) && !$stable(fill_idx_o)) |-> done_valid_o);

  // R8
  irq_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_valid_o);

  // R3
  stop_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode == 2'b00) |-> !st_ready_o);

  // R3
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode == 2'b01 && !st_ready_o && !reg_we_i) |=> !st_ready_o);

  // R4
  host_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(host_idx) && $stable(ring_mask)) |-> host_idx[2:0] == $past(host_idx[2:0]));
endmodule

bind rx_ring_dma rx_ring_dma_chk i_rx_ring_dma_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .cfg_mode    (cfg_word[31:30]),
  .ring_mask   (ring_mask),
  .host_idx    (host_idx),
  .fill_idx_o  (fill_idx_o),
  .done_idx_o  (done_idx_o),
  .done_valid_o(done_valid_o),
  .irq_o       (irq_o),
  .st_ready_o  (st_ready_o)
);

// File: tb/test_rx_ring_dma.sv
`timescale 1ns/100ps
module test_rx_ring_dma;
  localparam int BUF_UNIT = 64;
  localparam int BEAT_B   = 4;
  localparam int UB       = BUF_UNIT / BEAT_B;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        us_tick_i = 1'b0;
  logic        st_valid_i = 1'b0, st_sof_i = 1'b0, st_eof_i = 1'b0;
  logic        st_ready_o, done_valid_o, irq_o;
  logic [11:0] done_idx_o, fill_idx_o;

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, irq_cnt = 0, last_idx = -1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_ring_dma #(.BUF_UNIT(BUF_UNIT), .BEAT_BYTES(BEAT_B)) i_rx_ring_dma (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .us_tick_i(us_tick_i),
    .st_valid_i(st_valid_i), .st_sof_i(st_sof_i), .st_eof_i(st_eof_i),
    .st_ready_o(st_ready_o), .done_valid_o(done_valid_o), .done_idx_o(done_idx_o),
    .fill_idx_o(fill_idx_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    #1;
    if (rst_ni && done_valid_o) begin
      done_cnt++;
      last_idx = int'(done_idx_o);
    end
    if (rst_ni && irq_o) irq_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [31:0] cfgw(input logic [1:0] mode, input logic [3:0] lg,
                                       input logic [1:0] sz, input logic [1:0] dest,
                                       input logic [7:0] tmo);
    return {mode, 6'b0, lg, 2'b0, sz, 2'b0, dest, tmo, 4'b0};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic beat(input logic sof, input logic eof);
    st_valid_i = 1'b1; st_sof_i = sof; st_eof_i = eof;
    @(negedge clk);
    st_valid_i = 1'b0; st_sof_i = 1'b0; st_eof_i = 1'b0;
  endtask

  task automatic frame(input int n);
    for (int i = 0; i < n; i++) beat(i == 0, i == n - 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd2, d);
    chk(d[24] == 1'b1, "R9 idle after reset", int'(d[24]), 1);
    chk(d[11:0] == 12'd0, "R6 fill index after reset", int'(d[11:0]), 0);
    chk(st_ready_o == 1'b0, "R3 not ready after reset", int'(st_ready_o), 0);
    chk(irq_o == 1'b0 && done_valid_o == 1'b0, "R8 no event after reset", int'(irq_o), 0);
  endtask

  task automatic t_overflow_empty();
    logic [31:0] d;
    wr(2'd0, cfgw(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    rd(2'd2, d);
    chk(st_ready_o == 1'b1 && d[24] == 1'b0, "R3 run mode ready, R9 not idle", int'(d[24]), 0);
    for (int i = 0; i < 4; i++) beat(i == 0, i == 3);
    rd(2'd3, d);
    chk(d == 32'd16, "R5 overflow bytes with no free descriptor", int'(d), 16);
    chk(done_cnt == 0 && fill_idx_o == 12'd0, "R5 nothing filled when full", done_cnt, 0);
  endtask

  task automatic t_host_index();
    logic [31:0] d;
    wr(2'd1, 32'd3);
    rd(2'd1, d);
    chk(d == 32'd0, "R4 non multiple of eight rejected", int'(d), 0);
    wr(2'd1, 32'd8);
    rd(2'd1, d);
    chk(d == 32'd8, "R4 step of eight accepted", int'(d), 8);
  endtask

  task automatic t_fill_4k();
    logic [31:0] d;
    for (int i = 0; i < UB - 1; i++) beat(i == 0, 1'b0);
    chk(done_cnt == 0, "R2 no close before buffer full", done_cnt, 0);
    beat(1'b0, 1'b1);
    chk(done_cnt == 1 && last_idx == 0, "R6 completion of index 0", last_idx, 0);
    chk(irq_cnt == 1, "R8 host irq with completion", irq_cnt, 1);
    rd(2'd2, d);
    chk(d[11:0] == 12'd1, "R6 published fill index", int'(d[11:0]), 1);
  endtask

  task automatic t_fill_8k();
    wr(2'd0, cfgw(2'b10, 4'd5, 2'b01, 2'b01, 8'd0));
    for (int i = 0; i < UB; i++) beat(i == 0, 1'b0);
    chk(done_cnt == 1, "R2 size select 01 holds more than one unit", done_cnt, 1);
    for (int i = 0; i < UB; i++) beat(1'b0, i == UB - 1);
    chk(done_cnt == 2 && last_idx == 1, "R2 close at two units", last_idx, 1);
    chk(fill_idx_o == 12'd2, "R6 fill index after second close", int'(fill_idx_o), 2);
  endtask

  task automatic t_timeout();
    wr(2'd0, cfgw(2'b10, 4'd5, 2'b00, 2'b01, 8'd1));
    us_tick_i = 1'b1;
    beat(1'b1, 1'b0); beat(1'b0, 1'b0); beat(1'b0, 1'b1);
    repeat (31) @(negedge clk);
    chk(done_cnt == 2, "R7 no close one tick early", done_cnt, 2);
    @(negedge clk);
    chk(done_cnt == 3 && last_idx == 2, "R7 timeout closes partial buffer", last_idx, 2);
    chk(fill_idx_o == 12'd3, "R7 fill index after timeout", int'(fill_idx_o), 3);
    wr(2'd0, cfgw(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
  endtask

  task automatic t_full_wrap();
    logic [31:0] d;
    for (int b = 0; b < 5; b++) frame(UB);
    chk(done_cnt == 8 && last_idx == 7, "R5 fill up to host index", last_idx, 7);
    beat(1'b1, 1'b1);
    rd(2'd3, d);
    chk(d == 32'd20, "R5 drop when fill equals host index", int'(d), 20);
    chk(fill_idx_o == 12'd8, "R5 fill index held at host index", int'(fill_idx_o), 8);
    wr(2'd1, 32'h3E0);
    rd(2'd1, d);
    chk(d == 32'd0, "R1 host index masked to 32 entries", int'(d), 0);
    for (int b = 0; b < 24; b++) frame(UB);
    chk(done_cnt == 32 && last_idx == 31, "R1 last ring entry closed", last_idx, 31);
    chk(fill_idx_o == 12'd0, "R1 fill index wraps to zero", int'(fill_idx_o), 0);
    beat(1'b1, 1'b1);
    rd(2'd3, d);
    chk(d == 32'd24 && done_cnt == 32, "R5 ring holds at most size-1 after wrap", int'(d), 24);
  endtask

  task automatic t_no_irq();
    int irq0;
    irq0 = irq_cnt;
    wr(2'd1, 32'd8);
    wr(2'd0, cfgw(2'b10, 4'd5, 2'b00, 2'b00, 8'd0));
    frame(UB);
    chk(done_cnt == 33 && last_idx == 0, "R8 completion still reported", last_idx, 0);
    chk(irq_cnt == irq0, "R8 no irq with target 00", irq_cnt, irq0);
  endtask

  task automatic t_pause();
    logic [31:0] d, ovf0;
    beat(1'b1, 1'b0);
    wr(2'd0, cfgw(2'b01, 4'd5, 2'b00, 2'b01, 8'd0));
    rd(2'd2, d);
    chk(st_ready_o == 1'b1 && d[24] == 1'b0, "R3 pause keeps frame running", int'(st_ready_o), 1);
    beat(1'b0, 1'b1);
    rd(2'd2, d);
    chk(st_ready_o == 1'b0, "R3 refused after end of frame", int'(st_ready_o), 0);
    chk(d[24] == 1'b1, "R9 idle after pause reached frame end", int'(d[24]), 1);
    rd(2'd3, ovf0);
    beat(1'b1, 1'b1);
    rd(2'd3, d);
    chk(d == ovf0 && fill_idx_o == 12'd1 && done_cnt == 33, "R3 refused beat has no effect", int'(d), int'(ovf0));
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(2'd0, 32'd0);
    rd(2'd2, d);
    chk(d[24] == 1'b1 && st_ready_o == 1'b0, "R9 idle after config cleared", int'(d[24]), 1);
    wr(2'd0, cfgw(2'b11, 4'd5, 2'b00, 2'b01, 8'd0));
    chk(st_ready_o == 1'b0, "R3 reserved mode accepts nothing", int'(st_ready_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_overflow_empty();
    t_host_index();
    t_fill_4k();
    t_fill_8k();
    t_timeout();
    t_full_wrap();
    t_no_irq();
    t_pause();
    t_stop();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule